// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an asynchronous byte-wide static RAM with 512K locations. The host issues one access at a time over a request/ready handshake. It supplies an address, a direction flag and, for stores, a data byte. The controller then produces the active-low chip-select, write-strobe and output-gate signals on the memory side. It holds each phase for as many clock cycles as the memory's nanosecond minimums require. A load returns its byte on the host read-data port with a one-cycle valid strobe.

Every phase length is computed from the clock period with a ceiling division, so the block can be retimed for another clock by changing one parameter. The memory data bus is split into a drive value, a drive enable and a sampled input. The controller keeps its own drive off the bus while the memory may still be driving it. It changes the memory address only while all three strobes are inactive.

Top module: `async_sram_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, chip-select, write-strobe and output-gate are all high, the data drive enable is low, host ready is high and read-valid is low.
- R2: A load holds chip-select and output-gate low and write-strobe high for exactly max(ceil(55/T), ceil(30/T)) cycles, where T is the clock period in ns (7 cycles at 8 ns).
- R3: A load returns the byte last stored at that address, or 0 for an address never stored. The memory bus is sampled at the clock edge that ends the load phase. Read-valid is high for exactly one cycle, in the first cycle after chip-select returns high.
- R4: A store holds chip-select and write-strobe low for exactly max(ceil(45/T), ceil(50/T), ceil(25/T)+1, ceil(55/T)-1) cycles (7 at 8 ns). Output-gate stays high for the whole store.
- R5: The data drive enable is low in the first cycle of the write-strobe pulse. It is high from the second cycle of that pulse through the one cycle after write-strobe rises, and low after that. It is never high while output-gate is low.
- R6: The memory address does not change in any cycle where chip-select is low in both that cycle and the one before.
- R7: Before chip-select falls again, it stays high for at least ceil(20/T) cycles (3 at 8 ns) after a load and at least 1 cycle after a store.
- R8: Host ready is high only when the controller is idle. It is low in the cycle after a request is accepted and stays low until the access and its recovery are complete.
- R9: Back-to-back accesses in any mix of loads and stores to the same or different addresses, including address 0 and the top address, return data consistent with program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, accepted when host_ready is high |
| host_we | input | 1 | 1 = store, 0 = load |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Store data |
| host_ready | output | 1 | Controller idle and able to accept a request |
| host_rdata | output | 8 | Loaded byte |
| host_rvalid | output | 1 | One-cycle strobe marking host_rdata valid |
| ram_ce_n | output | 1 | Memory chip-select, active low |
| ram_we_n | output | 1 | Memory write-strobe, active low |
| ram_oe_n | output | 1 | Memory output-gate, active low |
| ram_addr | output | 19 | Memory address |
| ram_dq_out | output | 8 | Value driven onto the memory data bus |
| ram_dq_oe | output | 1 | Enable for the controller's data bus drivers |
| ram_dq_in | input | 8 | Value sampled from the memory data bus |

## Verification
The assertions check several things on every cycle: the legal strobe combinations, the absence of bus contention, the late start of data drive, address stability under an active select, the minimum idle cycle, ready dropping after acceptance, and the single-cycle valid strobe. The bench measures the exact phase lengths and recovery gaps, which depend on the parameters. It checks read data returned in program order against a scoreboard, using a memory model that returns garbage until its access time has elapsed. Only those scenarios can show that sampling is not early and that stored bytes land at the right address.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_REC
  } seq_state_t;

  function automatic int unsigned ceil_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // load phase: access from select, access from output gate, cycle minimum
  function automatic int unsigned read_cycles(input int unsigned rc_ns, input int unsigned aa_ns,
                                              input int unsigned oe_ns, input int unsigned clk_ns);
    return max2(1, max2(ceil_cyc(rc_ns, clk_ns), max2(ceil_cyc(aa_ns, clk_ns), ceil_cyc(oe_ns, clk_ns))));
  endfunction

  // store pulse: pulse width, select-to-end, data setup (drive starts one cycle late),
  // cycle minimum less the mandatory idle cycle
  function automatic int unsigned write_cycles(input int unsigned wp_ns, input int unsigned cw_ns,
                                               input int unsigned dw_ns, input int unsigned wc_ns,
                                               input int unsigned clk_ns);
    int unsigned n;
    n = max2(ceil_cyc(wp_ns, clk_ns), ceil_cyc(cw_ns, clk_ns));
    n = max2(n, ceil_cyc(dw_ns, clk_ns) + 1);
    n = max2(n, ceil_cyc(wc_ns, clk_ns) - 1);
    return max2(n, 2);
  endfunction

  function automatic int unsigned recover_cycles(input int unsigned hz_ns, input int unsigned clk_ns);
    return max2(1, ceil_cyc(hz_ns, clk_ns));
  endfunction

endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned RD_CYC = 7,
  parameter int unsigned WR_CYC = 7,
  parameter int unsigned RD_REC = 3,
  parameter int unsigned WR_REC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             write_phase,
  output logic             host_ready,
  output logic             ram_ce_n,
  output logic             ram_we_n,
  output logic             ram_oe_n
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (host_req) begin
        state_d  = host_we ? ST_WRITE : ST_READ;
        tmr_load = 1'b1;
        tmr_val  = host_we ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      ST_READ: if (tmr_done) begin
        state_d  = ST_REC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RD_REC - 1);
      end
      ST_WRITE: if (tmr_done) begin
        state_d  = ST_REC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WR_REC - 1);
      end
      ST_REC: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign accept      = (state_q == ST_IDLE) && host_req;
  assign capture     = (state_q == ST_READ) && tmr_done;
  assign write_phase = (state_q == ST_WRITE);
  assign host_ready  = (state_q == ST_IDLE);

  // strobes registered from the next state: glitch-free, aligned with the state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ram_ce_n <= 1'b1;
      ram_we_n <= 1'b1;
      ram_oe_n <= 1'b1;
    end else begin
      state_q  <= state_d;
      ram_ce_n <= !((state_d == ST_READ) || (state_d == ST_WRITE));
      ram_we_n <= !(state_d == ST_WRITE);
      ram_oe_n <= !(state_d == ST_READ);
    end
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              write_phase,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_addr    <= '0;
      ram_dq_out  <= '0;
      ram_dq_oe   <= 1'b0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      if (accept) begin
        ram_addr   <= host_addr;
        ram_dq_out <= host_wdata;
      end
      // one cycle behind the write strobe on both edges
      ram_dq_oe   <= write_phase;
      host_rvalid <= capture;
      if (capture) host_rdata <= ram_dq_in;
    end
  end
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 8,
  parameter int unsigned T_RC_NS = 55,
  parameter int unsigned T_AA_NS = 55,
  parameter int unsigned T_OE_NS = 30,
  parameter int unsigned T_WP_NS = 45,
  parameter int unsigned T_CW_NS = 50,
  parameter int unsigned T_DW_NS = 25,
  parameter int unsigned T_WC_NS = 55,
  parameter int unsigned T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int unsigned RD_CYC  = read_cycles(T_RC_NS, T_AA_NS, T_OE_NS, CLK_NS);
  localparam int unsigned WR_CYC  = write_cycles(T_WP_NS, T_CW_NS, T_DW_NS, T_WC_NS, CLK_NS);
  localparam int unsigned RD_REC  = recover_cycles(T_HZ_NS, CLK_NS);
  localparam int unsigned WR_REC  = 1;
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WR_CYC), RD_REC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  // named internal events, observed by the bound checker
  logic             accept;
  logic             capture;
  logic             write_phase;
  logic             tmr_load;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_val;

  sram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .RD_REC (RD_REC),
    .WR_REC (WR_REC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (accept),
    .capture     (capture),
    .write_phase (write_phase),
    .host_ready  (host_ready),
    .ram_ce_n    (ram_ce_n),
    .ram_we_n    (ram_we_n),
    .ram_oe_n    (ram_oe_n)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .capture     (capture),
    .write_phase (write_phase),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .ram_dq_in   (ram_dq_in),
    .ram_addr    (ram_addr),
    .ram_dq_out  (ram_dq_out),
    .ram_dq_oe   (ram_dq_oe),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );
endmodule

// File: rtl/async_sram_ctl_chk.sv
module async_sram_ctl_chk #(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic              ram_ce_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_oe,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              accept,
  input logic              capture
);
  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (ram_we_n && !ram_ce_n));

  a_r4_write_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (ram_oe_n && !ram_ce_n));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n);

  a_r5_drive_late: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> (!ram_we_n && !$past(ram_we_n)));

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && !$past(ram_ce_n)) |-> $stable(ram_addr));

  a_r7_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_ce_n) |=> ram_ce_n);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !host_ready);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> ram_ce_n);

  a_r3_valid_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> host_rvalid);

  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);
endmodule

bind async_sram_ctl async_sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_ready  (host_ready),
  .host_rvalid (host_rvalid),
  .ram_ce_n    (ram_ce_n),
  .ram_we_n    (ram_we_n),
  .ram_oe_n    (ram_oe_n),
  .ram_dq_oe   (ram_dq_oe),
  .ram_addr    (ram_addr),
  .accept      (accept),
  .capture     (capture)
);

// File: tb/async_sram_ctl_test.sv
module async_sram_ctl_test;
  localparam int AW    = 19;
  localparam int DW    = 8;
  localparam int RD_N  = 7;   // ceil(55/8)
  localparam int WR_N  = 7;   // largest of 6, 7, 4+1, 7-1
  localparam int RREC  = 3;   // ceil(20/8)
  localparam int WREC  = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_req, host_we;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic          host_ready, host_rvalid;
  logic [DW-1:0] host_rdata;
  logic          ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_dq_out, ram_dq_in;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [DW-1:0] ram_mem [int];
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] exp_q [$];

  always #4 clk = ~clk;

  async_sram_ctl uut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_addr(ram_addr),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] ram_get(input int a);
    return ram_mem.exists(a) ? ram_mem[a] : '0;
  endfunction

  function automatic logic [DW-1:0] ref_get(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : '0;
  endfunction

  // memory model and protocol monitor, all sampled mid-cycle
  bit            prev_ce = 1, prev_we = 1, prev_dqoe = 0, prev_rv = 0;
  logic [AW-1:0] prev_addr = '0;
  int            ce_run = 0, hi_run = 100, rd_age = 0;
  bit            run_is_write = 0, last_read = 0;
  logic [DW-1:0] wd_latch = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ram_dq_in = '0;
      rd_age = 0;
    end else begin
      if (!ram_ce_n) begin
        if (prev_ce) begin
          check(hi_run >= (last_read ? RREC : WREC), "R7 idle before select", hi_run, last_read ? RREC : WREC);
          ce_run = 0;
          run_is_write = !ram_we_n;
        end else begin
          check(ram_addr == prev_addr, "R6 address held", ram_addr, prev_addr);
        end
        ce_run++;
        hi_run = 0;
      end else begin
        if (!prev_ce) begin
          if (run_is_write) begin
            check(ce_run == WR_N, "R4 store length", ce_run, WR_N);
            check(!host_rvalid, "R3 no valid after store", host_rvalid, 0);
          end else begin
            check(ce_run == RD_N, "R2 load length", ce_run, RD_N);
            check(host_rvalid, "R3 valid after load", host_rvalid, 1);
          end
          last_read = !run_is_write;
        end
        hi_run++;
      end
      if (!ram_we_n && !ram_oe_n) check(0, "R4 gate low during store", 0, 1);
      if (ram_dq_oe && !ram_oe_n) check(0, "R5 bus contention", 1, 0);
      if (!ram_we_n && prev_we) check(!ram_dq_oe, "R5 no drive first strobe cycle", ram_dq_oe, 0);
      if (ram_we_n && !prev_we) begin
        check(ram_dq_oe, "R5 drive held after strobe rise", ram_dq_oe, 1);
        ram_mem[int'(ram_addr)] = wd_latch;
      end
      if (ram_we_n && prev_dqoe && !ram_dq_oe) check(hi_run == 2 || !ram_ce_n, "R5 release timing", hi_run, 2);
      if (!ram_we_n && ram_dq_oe) wd_latch = ram_dq_out;
      if (host_rvalid) begin
        check(!prev_rv, "R3 single valid", prev_rv, 0);
        if (exp_q.size() == 0) check(0, "R3 unexpected valid", host_rdata, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(host_rdata == e, "R3 R9 load data", host_rdata, e);
        end
      end
      // memory output: garbage until its access time has elapsed
      if (!ram_ce_n && !ram_oe_n && ram_we_n) rd_age++;
      else rd_age = 0;
      ram_dq_in = (rd_age >= RD_N) ? ram_get(int'(ram_addr)) : ~ram_get(int'(ram_addr));
      prev_ce   = ram_ce_n;
      prev_we   = ram_we_n;
      prev_dqoe = ram_dq_oe;
      prev_addr = ram_addr;
      prev_rv   = host_rvalid;
    end
  end

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    if (we) ref_mem[int'(a)] = d;
    else exp_q.push_back(ref_get(int'(a)));
    @(negedge clk);
    host_req = 1'b0;
    check(!host_ready, "R8 busy after accept", host_ready, 0);
  endtask

  task automatic check_idle_state(input string tag);
    check(ram_ce_n && ram_we_n && ram_oe_n, tag, {ram_ce_n, ram_we_n, ram_oe_n}, 3'b111);
    check(!ram_dq_oe, tag, ram_dq_oe, 0);
    check(host_ready && !host_rvalid, tag, {host_ready, host_rvalid}, 2'b10);
  endtask

  initial begin
    logic [7:0] lfsr;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    ram_dq_in = '0;
    repeat (3) @(negedge clk);
    check_idle_state("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_state("R1 after reset");

    // load of an unwritten location returns 0
    do_op(0, 19'h00123, 8'h00);
    // stores and loads at the address extremes
    do_op(1, 19'h00000, 8'hA5);
    do_op(1, 19'h7FFFF, 8'h3C);
    do_op(0, 19'h7FFFF, 8'h00);
    do_op(0, 19'h00000, 8'h00);
    // R9 store then immediate load of the same address, then overwrite
    do_op(1, 19'h2AAAA, 8'hFF);
    do_op(0, 19'h2AAAA, 8'h00);
    do_op(1, 19'h2AAAA, 8'h01);
    do_op(0, 19'h2AAAA, 8'h00);
    do_op(0, 19'h2AAAA, 8'h00);

    // R9 mixed pattern over a small address set
    lfsr = 8'h5B;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      do_op(lfsr[0], {lfsr[4] ? 16'hFFFF : 16'h0000, lfsr[3:1]}, lfsr ^ 8'h96);
    end

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all loads returned", exp_q.size(), 0);
    check_idle_state("R1 R8 idle at end");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule